// File: doc/BRIEF.md
# Serial Debug Port Sequencer

This block is the slave end of a bit-serial debug link through which an external tool drives a processor core held in debug mode. The tool sends frames of 35 bits. Each frame holds a start bit, a mode bit, a control bit and a 32-bit payload. The port decodes each frame into one of five actions: hand an instruction to the core, hand a data word to the core, load the trap-enable field, drop the breakpoint requests, or do nothing. At the same time it shifts a 35-bit status frame back to the tool. That frame holds a ready bit, a two-bit status code and a 32-bit data word.

On the core side the port sees two levels, one for an instruction fetch and one for a data read. It answers a request with a one-cycle acknowledge and the payload, or with a one-cycle bus error. A bus error is returned when the tool sent the wrong kind of word for what the core asked for. The port also keeps a small set of pending status events: a word the core has put in the data register, a sequencing error, and a core interrupt. It reports them one per frame in a fixed priority order. A frame that carries an error or interrupt report has its own input thrown away.

Top module: `dbg_serial_seq`

## Requirements
- R1: While no frame is in progress, `ser_out` is 0 when `core_ireq` or `core_dreq` is high, and 1 otherwise.
- R2: A frame begins on the first clock where `ser_in` is 1 while idle; zeros between frames are ignored. Input bits after the start bit, each captured on a rising edge, are: mode, control, then the payload MSB first. Output bits, starting at the ready bit, are: ready, status bit 1, status bit 0, then data MSB first.
- R3: Mode 0 / control 0 while `core_ireq` is high pulses `core_ack` for one cycle, with `core_payload` equal to the payload, in the cycle after the last bit is captured.
- R4: Mode 0 / control 1 while `core_dreq` is high pulses `core_ack` for one cycle, with the payload on `core_payload`.
- R5: Mode 1 / control 0 loads `trap_en` with payload bits 31:25; the lower payload bits have no effect. `trap_en` changes at no other time and resets to 0.
- R6: Mode 1 / control 1 with payload bits 31:25 equal to 7'b0011111 pulses `brk_negate` for one cycle. With those bits all zero, the frame is a no-op and no output changes.
- R7: An instruction frame while `core_dreq` is high, or a data frame while `core_ireq` is high, pulses `core_berr` instead of `core_ack`. The next status frame reports a sequencing error, and the frame after that reports an interrupt.
- R8: A `core_wr_valid` pulse stores `core_wr_data`. The next status frame reports valid data with that word. This status wins over a pending interrupt, which is kept and reported in the following frame.
- R9: Status codes are 00 valid data, 01 sequencing error, 10 interrupt, 11 nothing pending. The data field is zero for every code except 00.
- R10: The input of a frame whose status is 01 or 10 is discarded: no acknowledge, bus error, trap-enable load or breakpoint negate results from it.
- R11: A `core_intr` pulse makes the next status frame with no valid data pending report code 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial shift clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial frame input from the tool |
| ser_out | output | 1 | Serial status output / ready line |
| core_ireq | input | 1 | Core is waiting for an instruction |
| core_dreq | input | 1 | Core is waiting for a data word |
| core_intr | input | 1 | Core interrupt recognised (pulse) |
| core_wr_valid | input | 1 | Core writes the port data register (pulse) |
| core_wr_data | input | 32 | Word written by the core |
| core_ack | output | 1 | One-cycle completion of a core read |
| core_berr | output | 1 | One-cycle bus error to the core |
| core_payload | output | 32 | Word delivered with `core_ack` |
| trap_en | output | 7 | Trap-enable field |
| brk_negate | output | 1 | One-cycle breakpoint-negate command |

## Verification
A shift counter that drifts by one bit shows up quickly. Every field of the next status frame moves by one position, and the decoded action lands on the wrong mode/control pair. Both are visible within the same 35-cycle frame. A pending flag that is not cleared, or is cleared too early, shows up as a repeated or missing status code one frame later. A discard flag left stuck changes `trap_en` or pulses `core_ack` on a frame that should have been ignored, one cycle after that frame ends.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int DW      = 32;
    localparam int RX_W    = DW + 2;
    localparam int TX_W    = DW + 2;
    localparam int TRAP_W  = 7;
    localparam logic [TRAP_W-1:0] CMD_BRK_NEG = 7'b0011111;

    typedef enum logic [1:0] {
        ST_DATA = 2'b00,
        ST_SEQ  = 2'b01,
        ST_INT  = 2'b10,
        ST_NULL = 2'b11
    } stat_e;

    typedef enum logic [1:0] {
        OP_INSN = 2'b00,
        OP_DATA = 2'b01,
        OP_TRAP = 2'b10,
        OP_CMD  = 2'b11
    } op_e;
endpackage

// File: rtl/dbg_rx.sv
module dbg_rx #(
    parameter int FW = 34
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    output logic          busy_o,
    output logic          start_o,
    output logic          done_o,
    output logic [FW-1:0] frame_o
);
    localparam int CW = $clog2(FW);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [FW-1:0] sh;
    } rx_t;

    rx_t st_d, st_q;

    assign busy_o  = st_q.busy;
    assign start_o = !st_q.busy && ser_in;
    assign done_o  = st_q.busy && (st_q.cnt == CW'(FW-1));
    assign frame_o = {st_q.sh[FW-2:0], ser_in};

    always_comb begin
        st_d = st_q;
        if (start_o) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.sh  = {st_q.sh[FW-2:0], ser_in};
            st_d.cnt = st_q.cnt + 1'b1;
            if (done_o) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dbg_status_arb.sv
module dbg_status_arb
    import dbg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic          dv_set_i,
    input  logic [DW-1:0] dv_data_i,
    input  logic          seq_set_i,
    input  logic          intr_set_i,
    output stat_e         code_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          dv;
        logic          seq;
        logic          intr;
        logic [DW-1:0] data;
    } pend_t;

    pend_t pd_d, pd_q;

    always_comb begin
        code_o = ST_NULL;
        data_o = '0;
        if (pd_q.dv) begin
            code_o = ST_DATA;
            data_o = pd_q.data;
        end else if (pd_q.seq) begin
            code_o = ST_SEQ;
        end else if (pd_q.intr) begin
            code_o = ST_INT;
        end
    end

    always_comb begin
        pd_d = pd_q;
        if (take_i) begin
            unique case (code_o)
                ST_DATA: pd_d.dv   = 1'b0;
                ST_SEQ:  pd_d.seq  = 1'b0;
                ST_INT:  pd_d.intr = 1'b0;
                default: ;
            endcase
        end
        if (dv_set_i) begin
            pd_d.dv   = 1'b1;
            pd_d.data = dv_data_i;
        end
        if (seq_set_i)  pd_d.seq  = 1'b1;
        if (intr_set_i) pd_d.intr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end
endmodule

// File: rtl/dbg_serial_seq.sv
module dbg_serial_seq
    import dbg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    output logic          ser_out,
    input  logic          core_ireq,
    input  logic          core_dreq,
    input  logic          core_intr,
    input  logic          core_wr_valid,
    input  logic [31:0]   core_wr_data,
    output logic          core_ack,
    output logic          core_berr,
    output logic [31:0]   core_payload,
    output logic [6:0]    trap_en,
    output logic          brk_negate
);
    typedef struct packed {
        logic [TX_W-1:0]   tx;
        logic              discard;
        logic [TRAP_W-1:0] trap;
        logic              ack;
        logic              berr;
        logic              brk;
        logic [DW-1:0]     pay;
    } top_t;

    top_t st_d, st_q;

    logic            rx_busy, frame_start, frame_done;
    logic [RX_W-1:0] frame;
    stat_e           stat_code;
    logic [DW-1:0]   stat_data;
    logic            seq_set;
    op_e             op;
    logic [DW-1:0]   pl;

    dbg_rx #(.FW(RX_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .busy_o  (rx_busy),
        .start_o (frame_start),
        .done_o  (frame_done),
        .frame_o (frame)
    );

    dbg_status_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (frame_start),
        .dv_set_i   (core_wr_valid),
        .dv_data_i  (core_wr_data),
        .seq_set_i  (seq_set),
        .intr_set_i (core_intr | seq_set),
        .code_o     (stat_code),
        .data_o     (stat_data)
    );

    assign op = op_e'(frame[RX_W-1 -: 2]);
    assign pl = frame[DW-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        st_d.berr = 1'b0;
        st_d.brk  = 1'b0;
        seq_set   = 1'b0;

        if (frame_start) begin
            st_d.tx      = {stat_code, stat_data};
            st_d.discard = (stat_code == ST_SEQ) || (stat_code == ST_INT);
        end else if (rx_busy) begin
            st_d.tx = {st_q.tx[TX_W-2:0], 1'b0};
        end

        if (frame_done && !st_q.discard) begin
            unique case (op)
                OP_INSN: begin
                    if (core_ireq) begin
                        st_d.ack = 1'b1;
                        st_d.pay = pl;
                    end else if (core_dreq) begin
                        st_d.berr = 1'b1;
                        seq_set   = 1'b1;
                    end
                end
                OP_DATA: begin
                    if (core_dreq) begin
                        st_d.ack = 1'b1;
                        st_d.pay = pl;
                    end else if (core_ireq) begin
                        st_d.berr = 1'b1;
                        seq_set   = 1'b1;
                    end
                end
                OP_TRAP: st_d.trap = pl[DW-1 -: TRAP_W];
                OP_CMD:  st_d.brk  = (pl[DW-1 -: TRAP_W] == CMD_BRK_NEG);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_out      = rx_busy ? st_q.tx[TX_W-1] : !(core_ireq || core_dreq);
    assign core_ack     = st_q.ack;
    assign core_berr    = st_q.berr;
    assign core_payload = st_q.pay;
    assign trap_en      = st_q.trap;
    assign brk_negate   = st_q.brk;
endmodule

// File: rtl/dbg_serial_seq_chk.sv
module dbg_serial_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_ireq,
    input logic       core_dreq,
    input logic       core_ack,
    input logic       core_berr,
    input logic       brk_negate,
    input logic [6:0] trap_en,
    input logic       frame_done
);
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> !core_ack);                                       // R3
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |-> $past(core_ireq || core_dreq));                   // R4
    AST_TRAP_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_done) |-> $stable(trap_en));                      // R5
    AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_negate |=> !brk_negate);                                   // R6
    AST_BERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_berr && core_ack));                                     // R7
    AST_BERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_berr |=> !core_berr);                                     // R7
    AST_ACTION_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack || core_berr || brk_negate) |-> $past(frame_done));  // R2
endmodule

bind dbg_serial_seq dbg_serial_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ireq  (core_ireq),
    .core_dreq  (core_dreq),
    .core_ack   (core_ack),
    .core_berr  (core_berr),
    .brk_negate (brk_negate),
    .trap_en    (trap_en),
    .frame_done (frame_done)
);

// File: tb/dbg_serial_seq_tb.sv
module dbg_serial_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic        core_ireq = 1'b0, core_dreq = 1'b0, core_intr = 1'b0;
    logic        core_wr_valid = 1'b0;
    logic [31:0] core_wr_data = '0;
    logic        core_ack, core_berr, brk_negate;
    logic [31:0] core_payload;
    logic [6:0]  trap_en;

    int n_chk = 0, n_fail = 0;
    logic [34:0] got;
    logic        s_ack, s_berr, s_brk;
    logic [31:0] s_pay;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_serial_seq u_dut (.*);

    task automatic chk(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] mc, input logic [31:0] pl);
        logic [34:0] word;
        word = {1'b1, mc, pl};
        for (int i = 0; i < 35; i++) begin
            @(negedge clk);
            got[34-i] = ser_out;
            ser_in = word[34-i];
        end
        @(negedge clk);
        ser_in = 1'b0;
        s_ack = core_ack; s_berr = core_berr; s_brk = brk_negate; s_pay = core_payload;
    endtask

    task automatic chk_status(input string req, input logic [1:0] code, input logic [31:0] data);
        chk(req, got[33:32] == code, got[33:32], code);
        chk(req, got[31:0] == data, got[31:0], data);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R5 reset", trap_en == 7'h0, trap_en, 0);
        chk("R1 reset", ser_out == 1'b1, ser_out, 1);
        chk("R3 reset", core_ack == 1'b0, core_ack, 0);
    endtask

    task automatic t_ready;
        core_ireq = 1'b1; @(negedge clk);
        chk("R1 ireq", ser_out == 1'b0, ser_out, 0);
        core_ireq = 1'b0; core_dreq = 1'b1; @(negedge clk);
        chk("R1 dreq", ser_out == 1'b0, ser_out, 0);
        core_dreq = 1'b0; repeat (8) @(negedge clk);
        chk("R2 idle zeros", ser_out == 1'b1 && !core_ack, ser_out, 1);
    endtask

    task automatic t_insn;
        core_ireq = 1'b1;
        xfer(2'b00, 32'hA5A5_0F0F);
        chk("R1 ready bit", got[34] == 1'b0, got[34], 0);
        chk_status("R9 null", 2'b11, 32'h0);
        chk("R3 ack", s_ack && !s_berr, s_ack, 1);
        chk("R3 payload", s_pay == 32'hA5A5_0F0F, s_pay, 32'hA5A5_0F0F);
        core_ireq = 1'b0;
    endtask

    task automatic t_data;
        core_dreq = 1'b1;
        xfer(2'b01, 32'h1234_5678);
        chk("R4 ack", s_ack && !s_berr, s_ack, 1);
        chk("R4 payload", s_pay == 32'h1234_5678, s_pay, 32'h1234_5678);
        core_dreq = 1'b0;
    endtask

    task automatic t_trap;
        xfer(2'b10, 32'hB5FF_FFFF);
        chk("R1 ready idle", got[34] == 1'b1, got[34], 1);
        chk("R5 trap", trap_en == 7'h5A, trap_en, 7'h5A);
        chk("R5 no ack", !s_ack, s_ack, 0);
    endtask

    task automatic t_brk_nop;
        xfer(2'b11, {7'b0011111, 25'h0});
        chk("R6 brk", s_brk == 1'b1, s_brk, 1);
        @(negedge clk);
        chk("R6 brk pulse", brk_negate == 1'b0, brk_negate, 0);
        xfer(2'b11, 32'h0);
        chk("R6 nop", !s_brk && !s_ack && !s_berr && trap_en == 7'h5A, {s_brk, s_ack, s_berr}, 0);
    endtask

    task automatic t_seq;
        core_ireq = 1'b1;
        xfer(2'b01, 32'hCAFE_0000);
        chk("R7 berr", s_berr && !s_ack, {s_berr, s_ack}, 2'b10);
        core_ireq = 1'b0;
        xfer(2'b10, 32'h0200_0000);
        chk_status("R7 seq code", 2'b01, 32'h0);
        chk("R10 discard seq", trap_en == 7'h5A, trap_en, 7'h5A);
        xfer(2'b10, 32'h0200_0000);
        chk_status("R7 intr after seq", 2'b10, 32'h0);
        chk("R10 discard intr", trap_en == 7'h5A, trap_en, 7'h5A);
        xfer(2'b11, 32'h0);
        chk_status("R9 null after", 2'b11, 32'h0);
    endtask

    task automatic t_valid;
        @(negedge clk);
        core_wr_valid = 1'b1; core_wr_data = 32'hDEAD_BEEF; core_intr = 1'b1;
        @(negedge clk);
        core_wr_valid = 1'b0; core_intr = 1'b0;
        xfer(2'b11, 32'h0);
        chk_status("R8 valid first", 2'b00, 32'hDEAD_BEEF);
        xfer(2'b11, 32'h0);
        chk_status("R8 intr deferred", 2'b10, 32'h0);
        xfer(2'b11, 32'h0);
        chk_status("R9 null", 2'b11, 32'h0);
    endtask

    task automatic t_intr;
        @(negedge clk);
        core_intr = 1'b1;
        @(negedge clk);
        core_intr = 1'b0;
        xfer(2'b11, {7'b0011111, 25'h0});
        chk_status("R11 intr", 2'b10, 32'h0);
        chk("R10 brk ignored", s_brk == 1'b0, s_brk, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ready();
        t_insn();
        t_data();
        t_trap();
        t_brk_nop();
        t_seq();
        t_valid();
        t_intr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule